// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the architectural bookkeeping that a 32-bit RISC core does in the cycle it enters an exception or interrupt handler. The core's pipeline presents the program counter of the instruction being abandoned, whether that instruction sits in a branch delay slot, and the current status register. It also presents either a synchronous exception request with its cause code or pending external and timer interrupt lines. The block chooses the cause and registers the return address, the fault address and the old status word. It produces the status word the core must adopt and the handler address to fetch from. It also pulses the side effects that the entry requires.

Every result is registered. Inputs sampled at a rising clock edge appear on the outputs just after that edge. The held registers (saved PC, fault address, saved status, cause error) keep their values between entries. The strobes (`take_valid`, `tlb_flush`, `pm_clr`, `rsv_kill`, `dslot_clr`) last exactly one cycle per entry. The handler address is formed by OR-ing three parts: the cause code placed at bits 11:8, an optional base register, and an optional all-ones top nibble. An unsupported cause code taken on the synchronous path produces no entry. It sets a sticky error flag instead.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every output is zero.
- R2: On an entry, `saved_pc` becomes `cur_pc`, minus 4 when `dslot_in` is 1, plus 4 when the cause is system call (code 0xC). Both adjustments apply together when both conditions hold.
- R3: On an entry, bit 13 (delay-slot marker) of `sr_new` equals `dslot_in`, and `dslot_clr` pulses for one cycle only when `dslot_in` was 1.
- R4: `fault_addr` is loaded with `cur_pc` only on an illegal-instruction entry (code 0x7). Every other entry leaves it unchanged.
- R5: On an entry, `saved_sr` captures `sr_in` unchanged. `sr_new` is `sr_in` with bits 1 (timer enable), 2 (interrupt enable), 5 and 6 cleared, bit 0 (supervisor) set, bit 13 as in R3, and all other bits (including bit 14) kept.
- R6: `tlb_flush`, `pm_clr` and `rsv_kill` are high for exactly the cycles in which `take_valid` is high.
- R7: On an entry, `take_pc` is the cause code shifted left by 8. It is OR-ed with `base_addr` when `base_en` is 1, and with 0xF0000000 when bit 14 of `sr_in` is 1.
- R8: A synchronous request whose code is 0 or at least `NUM_CAUSES` (15 by default) makes no entry, leaves `saved_pc`, `fault_addr`, `saved_sr`, `take_pc` and `sr_new` unchanged, and sets `cause_err`. `cause_err` then stays 1 until reset. No interrupt is taken in that cycle.
- R9: With no synchronous request, a timer interrupt is taken (code 0x5) only if `sr_in` bit 1 is 1. An external interrupt is taken (code 0x8) only if `sr_in` bit 2 is 1. When both qualify, the timer wins. Otherwise no entry is made.
- R10: A valid synchronous request in the same cycle as qualifying interrupts is taken with its own code, and the interrupts are not taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | PC of the instruction being abandoned |
| dslot_in | input | 1 | That instruction is in a branch delay slot |
| sr_in | input | 16 | Current status register |
| base_addr | input | 32 | Exception base address |
| base_en | input | 1 | Use `base_addr` when forming the vector |
| exc_valid | input | 1 | Synchronous exception request |
| exc_code | input | 4 | Cause code of the synchronous request |
| irq_ext | input | 1 | External interrupt pending |
| irq_tick | input | 1 | Timer interrupt pending |
| take_valid | output | 1 | One-cycle strobe: entry accepted |
| take_pc | output | 32 | Handler address of the last entry |
| sr_new | output | 16 | Status word to adopt after the last entry |
| dslot_clr | output | 1 | One-cycle strobe: clear the delay-slot flag |
| pm_clr | output | 1 | One-cycle strobe: clear both power-management enables |
| rsv_kill | output | 1 | One-cycle strobe: set the reservation address to all ones |
| tlb_flush | output | 1 | One-cycle strobe: flush translations |
| saved_pc | output | 32 | Return PC |
| fault_addr | output | 32 | Fault effective address |
| saved_sr | output | 16 | Status word before the entry |
| cause_err | output | 1 | Sticky: unsupported cause code seen |

## Verification
Several requests can arrive in the same cycle: a synchronous exception together with the timer and external interrupt lines, and the two interrupt lines together. The bench drives these combinations on one clock edge, with the enables in `sr_in` set and cleared in turn. It judges the winner from the code in bits 11:8 of `take_pc`, with the base disabled. A delay-slot system call is also provoked, so that both PC adjustments land on the same entry and must cancel. A bad code is presented next to pending interrupts, to show that the error path suppresses the interrupt.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int CODE_W = 4;

    // status register bit positions
    localparam int SR_SM  = 0;
    localparam int SR_TEE = 1;
    localparam int SR_IEE = 2;
    localparam int SR_DME = 5;
    localparam int SR_IME = 6;
    localparam int SR_DSX = 13;
    localparam int SR_EPH = 14;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [CODE_W-1:0] {
        CAUSE_TICK    = 4'h5,
        CAUSE_ILLEGAL = 4'h7,
        CAUSE_EXTIRQ  = 4'h8,
        CAUSE_SYSCALL = 4'hC
    } cause_e;

    typedef struct packed {
        logic  take;
        logic  bad;
        code_t code;
    } pick_t;

    function automatic logic code_in_range(code_t c, int unsigned n);
        return (c != '0) && (32'(c) < n);
    endfunction

endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
    import exc_entry_pkg::*;
#(
    parameter int unsigned NUM_CAUSES = 15
) (
    input  logic  exc_valid,
    input  code_t exc_code,
    input  logic  irq_ext,
    input  logic  irq_tick,
    input  logic  ie_en,
    input  logic  te_en,
    output pick_t pick
);

    always_comb begin
        pick = '0;
        if (exc_valid) begin
            if (code_in_range(exc_code, NUM_CAUSES)) begin
                pick.take = 1'b1;
                pick.code = exc_code;
            end else begin
                pick.bad = 1'b1;
            end
        end else if (irq_tick && te_en) begin
            pick.take = 1'b1;
            pick.code = code_t'(CAUSE_TICK);
        end else if (irq_ext && ie_en) begin
            pick.take = 1'b1;
            pick.code = code_t'(CAUSE_EXTIRQ);
        end
    end

endmodule

// File: rtl/exc_save_calc.sv
module exc_save_calc
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              dslot,
    input  code_t             code,
    input  logic [SR_W-1:0]   sr,
    output logic [ADDR_W-1:0] epc_nxt,
    output logic [SR_W-1:0]   sr_nxt,
    output logic              eear_load
);

    localparam logic [ADDR_W-1:0] INSN_STEP = ADDR_W'(4);

    always_comb begin
        epc_nxt = pc;
        if (dslot)
            epc_nxt = epc_nxt - INSN_STEP;
        if (code == code_t'(CAUSE_SYSCALL))
            epc_nxt = epc_nxt + INSN_STEP;
    end

    always_comb begin
        sr_nxt         = sr;
        sr_nxt[SR_TEE] = 1'b0;
        sr_nxt[SR_IEE] = 1'b0;
        sr_nxt[SR_DME] = 1'b0;
        sr_nxt[SR_IME] = 1'b0;
        sr_nxt[SR_SM]  = 1'b1;
        sr_nxt[SR_DSX] = dslot;
    end

    assign eear_load = (code == code_t'(CAUSE_ILLEGAL));

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HI_W   = 4
) (
    input  code_t             code,
    input  logic [ADDR_W-1:0] base,
    input  logic              base_en,
    input  logic              hi_sel,
    output logic [ADDR_W-1:0] vec
);

    localparam int LOW_PAD = ADDR_W - CODE_W - 8;
    localparam logic [ADDR_W-1:0] HI_MASK = {{HI_W{1'b1}}, {(ADDR_W-HI_W){1'b0}}};

    logic [ADDR_W-1:0] slot;
    logic [ADDR_W-1:0] base_part;
    logic [ADDR_W-1:0] hi_part;

    assign slot      = {{LOW_PAD{1'b0}}, code, 8'h00};
    assign base_part = base_en ? base : '0;
    assign hi_part   = hi_sel ? HI_MASK : '0;
    assign vec       = slot | base_part | hi_part;

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          SR_W       = 16,
    parameter int unsigned NUM_CAUSES = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              dslot_in,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              base_en,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_ext,
    input  logic              irq_tick,
    output logic              take_valid,
    output logic [ADDR_W-1:0] take_pc,
    output logic [SR_W-1:0]   sr_new,
    output logic              dslot_clr,
    output logic              pm_clr,
    output logic              rsv_kill,
    output logic              tlb_flush,
    output logic [ADDR_W-1:0] saved_pc,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [SR_W-1:0]   saved_sr,
    output logic              cause_err
);

    pick_t             pick;
    logic [ADDR_W-1:0] epc_nxt;
    logic [SR_W-1:0]   sr_nxt;
    logic              eear_load;
    logic [ADDR_W-1:0] vec;

    exc_cause_sel #(.NUM_CAUSES(NUM_CAUSES)) u_sel (
        .exc_valid (exc_valid),
        .exc_code  (exc_code),
        .irq_ext   (irq_ext),
        .irq_tick  (irq_tick),
        .ie_en     (sr_in[SR_IEE]),
        .te_en     (sr_in[SR_TEE]),
        .pick      (pick)
    );

    exc_save_calc #(.ADDR_W(ADDR_W), .SR_W(SR_W)) u_save (
        .pc        (cur_pc),
        .dslot     (dslot_in),
        .code      (pick.code),
        .sr        (sr_in),
        .epc_nxt   (epc_nxt),
        .sr_nxt    (sr_nxt),
        .eear_load (eear_load)
    );

    exc_vector_gen #(.ADDR_W(ADDR_W), .HI_W(4)) u_vec (
        .code    (pick.code),
        .base    (base_addr),
        .base_en (base_en),
        .hi_sel  (sr_in[SR_EPH]),
        .vec     (vec)
    );

    // one-cycle side-effect strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            take_valid <= 1'b0;
            tlb_flush  <= 1'b0;
            pm_clr     <= 1'b0;
            rsv_kill   <= 1'b0;
            dslot_clr  <= 1'b0;
        end else begin
            take_valid <= pick.take;
            tlb_flush  <= pick.take;
            pm_clr     <= pick.take;
            rsv_kill   <= pick.take;
            dslot_clr  <= pick.take && dslot_in;
        end
    end

    // held architectural state
    always_ff @(posedge clk) begin
        if (rst) begin
            take_pc    <= '0;
            sr_new     <= '0;
            saved_pc   <= '0;
            fault_addr <= '0;
            saved_sr   <= '0;
            cause_err  <= 1'b0;
        end else begin
            if (pick.take) begin
                take_pc  <= vec;
                sr_new   <= sr_nxt;
                saved_pc <= epc_nxt;
                saved_sr <= sr_in;
                if (eear_load)
                    fault_addr <= cur_pc;
            end
            if (pick.bad)
                cause_err <= 1'b1;
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int          SR_W       = 16,
    parameter int unsigned NUM_CAUSES = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              dslot_in,
    input logic [SR_W-1:0]   sr_in,
    input logic              exc_valid,
    input logic [CODE_W-1:0] exc_code,
    input logic              irq_ext,
    input logic              irq_tick,
    input logic              take_valid,
    input logic [4:0]        mode_bits,
    input logic              dsx_bit,
    input logic              pm_clr,
    input logic              rsv_kill,
    input logic              tlb_flush,
    input logic [SR_W-1:0]   saved_sr,
    input logic              cause_err
);

    logic bad_code;
    assign bad_code = exc_valid && ((exc_code == '0) || (32'(exc_code) >= NUM_CAUSES));

    // mode_bits = {IME, DME, IEE, TEE, SM}
    assert_mode_bits_R5: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (mode_bits == 5'b00001));

    assert_saved_sr_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && take_valid) |-> (saved_sr == $past(sr_in)));

    assert_dsx_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && take_valid) |-> (dsx_bit == $past(dslot_in)));

    assert_strobes_R6: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (tlb_flush && pm_clr && rsv_kill));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        cause_err |=> cause_err);

    assert_bad_no_take_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bad_code)) |-> (!take_valid && cause_err));

    assert_tick_taken_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(exc_valid) && $past(irq_tick) && $past(sr_in[SR_TEE]))
        |-> take_valid);

    assert_gated_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(exc_valid)
         && !($past(irq_tick) && $past(sr_in[SR_TEE]))
         && !($past(irq_ext) && $past(sr_in[SR_IEE])))
        |-> !take_valid);

endmodule

bind exc_entry_unit exc_entry_chk #(.SR_W(SR_W), .NUM_CAUSES(NUM_CAUSES)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .dslot_in   (dslot_in),
    .sr_in      (sr_in),
    .exc_valid  (exc_valid),
    .exc_code   (exc_code),
    .irq_ext    (irq_ext),
    .irq_tick   (irq_tick),
    .take_valid (take_valid),
    .mode_bits  ({sr_new[exc_entry_pkg::SR_IME], sr_new[exc_entry_pkg::SR_DME],
                  sr_new[exc_entry_pkg::SR_IEE], sr_new[exc_entry_pkg::SR_TEE],
                  sr_new[exc_entry_pkg::SR_SM]}),
    .dsx_bit    (sr_new[exc_entry_pkg::SR_DSX]),
    .pm_clr     (pm_clr),
    .rsv_kill   (rsv_kill),
    .tlb_flush  (tlb_flush),
    .saved_sr   (saved_sr),
    .cause_err  (cause_err)
);

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;

    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT    = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cur_pc = '0;
    logic        dslot_in = 1'b0;
    logic [15:0] sr_in = '0;
    logic [31:0] base_addr = '0;
    logic        base_en = 1'b0;
    logic        exc_valid = 1'b0;
    logic [3:0]  exc_code = '0;
    logic        irq_ext = 1'b0;
    logic        irq_tick = 1'b0;

    logic        take_valid, dslot_clr, pm_clr, rsv_kill, tlb_flush, cause_err;
    logic [31:0] take_pc, saved_pc, fault_addr;
    logic [15:0] sr_new, saved_sr;

    exc_entry_unit i_exc_entry_unit (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .dslot_in(dslot_in), .sr_in(sr_in),
        .base_addr(base_addr), .base_en(base_en), .exc_valid(exc_valid),
        .exc_code(exc_code), .irq_ext(irq_ext), .irq_tick(irq_tick),
        .take_valid(take_valid), .take_pc(take_pc), .sr_new(sr_new),
        .dslot_clr(dslot_clr), .pm_clr(pm_clr), .rsv_kill(rsv_kill),
        .tlb_flush(tlb_flush), .saved_pc(saved_pc), .fault_addr(fault_addr),
        .saved_sr(saved_sr), .cause_err(cause_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string       req;
        logic        take;
        logic [31:0] vec;
        logic [15:0] srn;
        logic [31:0] epc;
        logic [31:0] eear;
        logic [15:0] esr;
        logic        err;
        logic        dclr;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;

    // model state, from the requirements
    logic [31:0] m_vec = '0, m_epc = '0, m_eear = '0;
    logic [15:0] m_srn = '0, m_esr = '0;
    logic        m_err = 1'b0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected outcome
    task automatic step(string req, logic ev, logic [3:0] code, logic [31:0] pc,
                        logic ds, logic [15:0] sr, logic [31:0] base, logic ben,
                        logic ie, logic it);
        exp_t e;
        logic       tk = 1'b0;
        logic [3:0] c  = 4'h0;
        @(negedge clk);
        cur_pc = pc; dslot_in = ds; sr_in = sr; base_addr = base; base_en = ben;
        exc_valid = ev; exc_code = code; irq_ext = ie; irq_tick = it;
        if (ev) begin
            if (code != 4'h0 && code < 4'hF) begin tk = 1'b1; c = code; end
            else m_err = 1'b1;
        end else if (it && sr[1]) begin tk = 1'b1; c = 4'h5; end
        else if (ie && sr[2]) begin tk = 1'b1; c = 4'h8; end
        if (tk) begin
            m_epc = pc - (ds ? 32'd4 : 32'd0) + ((c == 4'hC) ? 32'd4 : 32'd0);
            if (c == 4'h7) m_eear = pc;
            m_esr = sr;
            m_srn = sr & ~16'h2066;
            m_srn[0] = 1'b1;
            m_srn[13] = ds;
            m_vec = {20'h0, c, 8'h00} | (ben ? base : 32'h0) | (sr[14] ? 32'hF000_0000 : 32'h0);
        end
        e.req = req; e.take = tk; e.vec = m_vec; e.srn = m_srn; e.epc = m_epc;
        e.eear = m_eear; e.esr = m_esr; e.err = m_err; e.dclr = tk && ds;
        q.push_back(e);
    endtask

    // monitor: compare after each edge that follows a pushed stimulus
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, "take_valid", 32'(take_valid), 32'(e.take));
                chk(e.req, "take_pc",    take_pc,         e.vec);
                chk(e.req, "sr_new",     32'(sr_new),     32'(e.srn));
                chk(e.req, "saved_pc",   saved_pc,        e.epc);
                chk(e.req, "fault_addr", fault_addr,      e.eear);
                chk(e.req, "saved_sr",   32'(saved_sr),   32'(e.esr));
                chk(e.req, "cause_err",  32'(cause_err),  32'(e.err));
                chk(e.req, "dslot_clr",  32'(dslot_clr),  32'(e.dclr));
                chk("R6", "tlb_flush",   32'(tlb_flush),  32'(e.take));
                chk("R6", "pm_clr",      32'(pm_clr),     32'(e.take));
                chk("R6", "rsv_kill",    32'(rsv_kill),   32'(e.take));
            end
        end
    end

    initial begin
        repeat (TIMEOUT) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with busy inputs
        exc_valid = 1'b1; exc_code = 4'h7; irq_tick = 1'b1; sr_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "take_valid", 32'(take_valid), 0);
        chk("R1", "take_pc", take_pc, 0);
        chk("R1", "saved_pc", saved_pc, 0);
        chk("R1", "cause_err", 32'(cause_err), 0);
        chk("R1", "tlb_flush", 32'(tlb_flush), 0);
        @(negedge clk);
        exc_valid = 1'b0; irq_tick = 1'b0; sr_in = 16'h0;
        rst = 1'b0;
        #1;
        chk("R1", "take_valid", 32'(take_valid), 0);

        // R2 R5: syscall outside delay slot, all enables set
        step("R2", 1, 4'hC, 32'h0000_1000, 0, 16'h0066, 32'h0, 0, 0, 0);
        // R2 R3: syscall in delay slot, adjustments cancel
        step("R3", 1, 4'hC, 32'h0000_1100, 1, 16'h0006, 32'h0, 0, 0, 0);
        // R4 R7: illegal instruction, base enabled
        step("R4", 1, 4'h7, 32'h0000_2000, 0, 16'h0000, 32'h0001_0000, 1, 0, 0);
        // R4 R7 R2: other cause in delay slot, top nibble select, fault addr held
        step("R7", 1, 4'h2, 32'h0000_3000, 1, 16'h4000, 32'h0001_0000, 0, 0, 0);
        // R7: base set but disabled
        step("R7", 1, 4'h3, 32'h0000_3100, 0, 16'h4066, 32'h0002_0000, 0, 0, 0);
        // R9: external pending, interrupt enable clear
        step("R9", 0, 4'h0, 32'h0000_4000, 0, 16'h0002, 32'h0, 0, 1, 0);
        // R9: timer pending, timer enable clear
        step("R9", 0, 4'h0, 32'h0000_4004, 0, 16'h0004, 32'h0, 0, 0, 1);
        // R9: timer gated off, external taken
        step("R9", 0, 4'h0, 32'h0000_4008, 0, 16'h0004, 32'h0, 0, 1, 1);
        // R9: both qualify, timer wins
        step("R9", 0, 4'h0, 32'h0000_400C, 1, 16'h0006, 32'h0, 0, 1, 1);
        // R10: synchronous request beats qualifying interrupts
        step("R10", 1, 4'h7, 32'h0000_5000, 0, 16'h0006, 32'h0, 0, 1, 1);
        // idle cycle
        step("R9", 0, 4'h0, 32'h0000_5004, 0, 16'h0006, 32'h0, 0, 0, 0);
        // R8: code 0 with interrupts pending
        step("R8", 1, 4'h0, 32'h0000_6000, 1, 16'h0006, 32'h0, 1, 1, 1);
        // R8: code 15
        step("R8", 1, 4'hF, 32'h0000_6004, 0, 16'h0006, 32'h0, 0, 0, 0);
        // R8: valid entry afterwards, error stays set
        step("R8", 1, 4'hE, 32'h0000_6008, 0, 16'h0000, 32'h0, 0, 0, 0);
        step("R8", 0, 4'h0, 32'h0000_600C, 0, 16'h0000, 32'h0, 0, 0, 0);

        @(negedge clk);
        exc_valid = 1'b0; irq_ext = 1'b0; irq_tick = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule